// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache private to one processor core. It holds copies of page-table entries, each mapping a virtual page number to a physical frame number with permission bits. Every entry also carries a 4-bit address-space tag, so translations belonging to several processes can stay resident side by side. A lookup is answered combinationally in the same cycle. It returns a hit with the frame and permissions, a plain miss, or a "needs walk" indication. The "needs walk" case arises when the cached entry's accessed or dirty state would have to change in memory. The entries are a read-only copy, so that update is left to the external page walker, which then refills the entry.

The page walker writes new translations through a fill port. Maintenance commands arrive on a second port:
- load a new page-table root, which also selects the current address-space tag;
- invalidate one virtual page;
- flush every entry;
- flush the entries of one tag.

When tagging is switched off, a root load also empties the buffer. When tagging is on, a root load only changes the current tag. Cross-core shootdowns, the walker and the caches all lie outside the block.

Top module: `ctx_tlb`

## Requirements
- R1: After synchronous reset no lookup hits, `lk_need_walk` is 0, and `cur_ctx` reads 0.
- R2: A lookup hits in the same cycle only when a valid entry has the looked-up VPN and a tag equal to `cur_ctx`. On a hit, `lk_pfn` and `lk_perm` carry the entry's frame and permissions. On anything but a hit, both read 0.
- R3: Entries with different tags coexist. An entry whose tag differs from `cur_ctx` never matches.
- R4: A matching lookup reports `lk_need_walk`=1 with `lk_hit`=0 when the entry's accessed bit is 0, or when `lk_write`=1 and its dirty bit is 0. Otherwise it reports a hit.
- R5: A fill with `fl_valid`=1 is placed as follows:
  - If an entry already matches the fill's VPN and current tag, the fill overwrites that entry.
  - Otherwise it goes to the lowest-numbered invalid entry.
  - Otherwise it goes to the entry named by a round-robin pointer. The pointer starts at 0 and advances by one, wrapping at 16, each time it is used.
- R6: `mt_op`=1 (root load) with `tag_en`=0 invalidates every entry and sets `cur_ctx` to `mt_ctx` from the next cycle.
- R7: `mt_op`=1 with `tag_en`=1 sets `cur_ctx` to `mt_ctx` and leaves all entries intact.
- R8: `mt_op`=2 invalidates every entry whose VPN equals `mt_vpn`, whatever its tag.
- R9: `mt_op`=3 invalidates every entry.
- R10: `mt_op`=4 invalidates exactly the entries tagged `mt_ctx`. Entries with other tags are untouched. `mt_op`=0 is no operation.
- R11: When a fill and an invalidation that covers the filled page occur in the same cycle, the invalidation wins and the fill leaves no valid entry.
- R12: A fill is tagged with the value of `cur_ctx` in the cycle it is presented, even if a root load in that same cycle changes `cur_ctx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_write | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Usable translation found |
| lk_need_walk | output | 1 | Entry matched but accessed/dirty state needs a walk |
| lk_pfn | output | 20 | Physical frame number on hit, else 0 |
| lk_perm | output | 3 | Permission bits on hit, else 0 |
| fl_valid | input | 1 | Fill request from the walker |
| fl_vpn | input | 20 | Fill virtual page number |
| fl_pfn | input | 20 | Fill physical frame number |
| fl_perm | input | 3 | Fill permission bits |
| fl_dirty | input | 1 | Fill dirty state |
| fl_accessed | input | 1 | Fill accessed state |
| mt_op | input | 3 | Maintenance command: 0 none, 1 root load, 2 page invalidate, 3 flush all, 4 flush one tag |
| mt_vpn | input | 20 | Page for command 2 |
| mt_ctx | input | 4 | Tag for commands 1 and 4 |
| tag_en | input | 1 | Address-space tagging enabled |
| cur_ctx | output | 4 | Current address-space tag |

## Verification
Lookups are exercised in four situations, each separating one matching rule:
- the same VPN under two tags, which shows the tag takes part in the match;
- reads and writes against entries whose accessed and dirty bits differ, which separates hit from needs-walk;
- twenty distinct fills into sixteen slots, which exposes the free-slot-then-round-robin victim order;
- refills of an existing page, which must overwrite rather than duplicate.

Each maintenance command is then applied with entries of several tags present. This shows which entries each command may remove, and that a root load flushes only with tagging off. A fill issued together with a matching invalidate shows which of the two takes priority.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
    localparam int VPN_W  = 20;
    localparam int PFN_W  = 20;
    localparam int CTX_W  = 4;
    localparam int PERM_W = 3;

    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [PFN_W-1:0]  pfn_t;
    typedef logic [CTX_W-1:0]  ctx_t;
    typedef logic [PERM_W-1:0] perm_t;

    typedef enum logic [2:0] {
        MT_NONE      = 3'd0,
        MT_ROOT      = 3'd1,
        MT_INV_PAGE  = 3'd2,
        MT_FLUSH_ALL = 3'd3,
        MT_FLUSH_CTX = 3'd4
    } mt_op_e;

    typedef struct packed {
        logic  valid;
        logic  dirty;
        logic  accessed;
        ctx_t  ctx;
        vpn_t  vpn;
        pfn_t  pfn;
        perm_t perm;
    } tlb_entry_t;

    function automatic logic tag_match(tlb_entry_t e, vpn_t v, ctx_t c);
        return e.valid && (e.vpn == v) && (e.ctx == c);
    endfunction

    // Decide whether a maintenance command removes an entry.
    function automatic logic kill_entry(mt_op_e op, logic tagging, tlb_entry_t e,
                                        vpn_t v, ctx_t c);
        case (op)
            MT_ROOT:      return !tagging;
            MT_INV_PAGE:  return e.vpn == v;
            MT_FLUSH_ALL: return 1'b1;
            MT_FLUSH_CTX: return e.ctx == c;
            default:      return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/ctx_tlb_cam.sv
module ctx_tlb_cam
    import ctx_tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_entry_t [N-1:0] ents,
    input  vpn_t               key_vpn,
    input  ctx_t               key_ctx,
    output logic [N-1:0]       match_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_vec[g] = tag_match(ents[g], key_vpn, key_ctx);
    end
endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         valid_vec,
    input  logic [N-1:0]         same_vec,
    input  logic                 take,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] rr_q, same_idx, free_idx;
    logic any_same, any_free, use_rr;

    always_comb begin
        same_idx = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (same_vec[i])   same_idx = IW'(i);
            if (!valid_vec[i]) free_idx = IW'(i);
        end
        any_same = |same_vec;
        any_free = ~&valid_vec;
        use_rr   = !any_same && !any_free;
        idx      = any_same ? same_idx : (any_free ? free_idx : rr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (take && use_rr) begin
            rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // R5: an entry chosen for its matching key must be the valid one holding that key
    assert_same_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (take && any_same) |-> valid_vec[idx]);
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_need_walk,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              fl_valid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [PFN_W-1:0]  fl_pfn,
    input  logic [PERM_W-1:0] fl_perm,
    input  logic              fl_dirty,
    input  logic              fl_accessed,
    input  logic [2:0]        mt_op,
    input  logic [VPN_W-1:0]  mt_vpn,
    input  logic [CTX_W-1:0]  mt_ctx,
    input  logic              tag_en,
    output logic [CTX_W-1:0]  cur_ctx
);
    localparam int IDX_W = $clog2(N_ENT);

    tlb_entry_t [N_ENT-1:0] ent_q, ent_d;
    ctx_t                   ctx_q;
    mt_op_e                 op;
    logic [N_ENT-1:0]       vld, lk_match, fl_same;
    logic [IDX_W-1:0]       vic_idx;

    assign op      = mt_op_e'(mt_op);
    assign cur_ctx = ctx_q;

    for (genvar g = 0; g < N_ENT; g++) begin : g_vld
        assign vld[g] = ent_q[g].valid;
    end

    ctx_tlb_cam #(.N(N_ENT)) u_lk_cam (
        .ents(ent_q), .key_vpn(lk_vpn), .key_ctx(ctx_q), .match_vec(lk_match)
    );

    ctx_tlb_cam #(.N(N_ENT)) u_fl_cam (
        .ents(ent_q), .key_vpn(fl_vpn), .key_ctx(ctx_q), .match_vec(fl_same)
    );

    ctx_tlb_victim #(.N(N_ENT)) u_victim (
        .clk(clk), .rst(rst), .valid_vec(vld), .same_vec(fl_same),
        .take(fl_valid), .idx(vic_idx)
    );

    // Next state: fill first, then apply the maintenance kill so it wins.
    always_comb begin
        ent_d = ent_q;
        if (fl_valid) begin
            ent_d[vic_idx] = '{valid: 1'b1, dirty: fl_dirty, accessed: fl_accessed,
                               ctx: ctx_q, vpn: fl_vpn, pfn: fl_pfn, perm: fl_perm};
        end
        for (int i = 0; i < N_ENT; i++) begin
            if (kill_entry(op, tag_en, ent_d[i], mt_vpn, mt_ctx)) ent_d[i].valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
            ctx_q <= '0;
        end else begin
            ent_q <= ent_d;
            if (op == MT_ROOT) ctx_q <= mt_ctx;
        end
    end

    // Lookup read-out: OR across the (at most one) matching entry.
    pfn_t  sel_pfn;
    perm_t sel_perm;
    logic  sel_dirty, sel_acc, any_match, walk;

    always_comb begin
        sel_pfn   = '0;
        sel_perm  = '0;
        sel_dirty = 1'b0;
        sel_acc   = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (lk_match[i]) begin
                sel_pfn   = sel_pfn | ent_q[i].pfn;
                sel_perm  = sel_perm | ent_q[i].perm;
                sel_dirty = sel_dirty | ent_q[i].dirty;
                sel_acc   = sel_acc | ent_q[i].accessed;
            end
        end
        any_match    = |lk_match;
        walk         = !sel_acc || (lk_write && !sel_dirty);
        lk_need_walk = any_match && walk;
        lk_hit       = any_match && !walk;
        lk_pfn       = lk_hit ? sel_pfn : '0;
        lk_perm      = lk_hit ? sel_perm : '0;
    end

    // R5: placement never creates a duplicate translation
    assert_unique_match_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    // R9: flush-all empties the buffer
    assert_flush_all_R9: assert property (@(posedge clk) disable iff (rst)
        (op == MT_FLUSH_ALL) |=> (vld == '0));

    // R6: untagged root load empties the buffer and moves the tag
    assert_root_untagged_R6: assert property (@(posedge clk) disable iff (rst)
        (op == MT_ROOT && !tag_en) |=> (vld == '0) && (cur_ctx == $past(mt_ctx)));

    // R7: tagged root load keeps every entry
    assert_root_tagged_R7: assert property (@(posedge clk) disable iff (rst)
        (op == MT_ROOT && tag_en && !fl_valid) |=> (vld == $past(vld)));

    for (genvar g = 0; g < N_ENT; g++) begin : g_chk
        // R8 and R11: no entry for the invalidated page survives, even one filled alongside
        assert_page_gone_R8: assert property (@(posedge clk) disable iff (rst)
            (op == MT_INV_PAGE) |=> !(ent_q[g].valid && ent_q[g].vpn == $past(mt_vpn)));
        // R10: no entry of the flushed tag survives
        assert_ctx_gone_R10: assert property (@(posedge clk) disable iff (rst)
            (op == MT_FLUSH_CTX) |=> !(ent_q[g].valid && ent_q[g].ctx == $past(mt_ctx)));
    end
endmodule

// File: tb/test_ctx_tlb.sv
`timescale 1ns/1ps
module test_ctx_tlb;
    import ctx_tlb_pkg::*;
    localparam int NE = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [VPN_W-1:0] lk_vpn = '0, fl_vpn = '0, mt_vpn = '0;
    logic lk_write = 1'b0, fl_valid = 1'b0, fl_dirty = 1'b0, fl_accessed = 1'b0, tag_en = 1'b0;
    logic [PFN_W-1:0] fl_pfn = '0;
    logic [PERM_W-1:0] fl_perm = '0;
    logic [2:0] mt_op = 3'd0;
    logic [CTX_W-1:0] mt_ctx = '0;
    logic lk_hit, lk_need_walk;
    logic [PFN_W-1:0] lk_pfn;
    logic [PERM_W-1:0] lk_perm;
    logic [CTX_W-1:0] cur_ctx;

    always #2.5 clk = ~clk;

    ctx_tlb #(.N_ENT(NE)) i_ctx_tlb (
        .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_need_walk(lk_need_walk), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn), .fl_perm(fl_perm),
        .fl_dirty(fl_dirty), .fl_accessed(fl_accessed), .mt_op(mt_op), .mt_vpn(mt_vpn),
        .mt_ctx(mt_ctx), .tag_en(tag_en), .cur_ctx(cur_ctx)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Behavioural reference model
    bit m_v[NE], m_d[NE], m_a[NE];
    int m_vpn[NE], m_pfn[NE], m_perm[NE], m_ctx[NE];
    int m_cur = 0, m_rr = 0;

    task automatic model_update();
        int v;
        if (fl_valid) begin
            v = -1;
            for (int i = 0; i < NE; i++)
                if (m_v[i] && m_vpn[i] == int'(fl_vpn) && m_ctx[i] == m_cur) v = i;
            if (v < 0)
                for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) v = i;
            if (v < 0) begin v = m_rr; m_rr = (m_rr + 1) % NE; end
            m_v[v] = 1; m_d[v] = fl_dirty; m_a[v] = fl_accessed;
            m_vpn[v] = int'(fl_vpn); m_pfn[v] = int'(fl_pfn);
            m_perm[v] = int'(fl_perm); m_ctx[v] = m_cur;
        end
        for (int i = 0; i < NE; i++) begin
            case (mt_op)
                3'd1: if (!tag_en) m_v[i] = 0;
                3'd2: if (m_vpn[i] == int'(mt_vpn)) m_v[i] = 0;
                3'd3: m_v[i] = 0;
                3'd4: if (m_ctx[i] == int'(mt_ctx)) m_v[i] = 0;
                default: ;
            endcase
        end
        if (mt_op == 3'd1) m_cur = int'(mt_ctx);
    endtask

    task automatic step(input string tag);
        bit f, eh, en;
        int hi, ep, epm;
        #1;
        f = 0; hi = 0;
        for (int i = 0; i < NE; i++)
            if (m_v[i] && m_vpn[i] == int'(lk_vpn) && m_ctx[i] == m_cur) begin f = 1; hi = i; end
        en  = f && (!m_a[hi] || (lk_write && !m_d[hi]));
        eh  = f && !en;
        ep  = eh ? m_pfn[hi] : 0;
        epm = eh ? m_perm[hi] : 0;
        n_chk++;
        if (lk_hit !== eh || lk_need_walk !== en || lk_pfn !== PFN_W'(ep) ||
            lk_perm !== PERM_W'(epm) || cur_ctx !== CTX_W'(m_cur)) begin
            n_fail++;
            $display("FAIL %s vpn=%h wr=%0b: hit=%0b walk=%0b pfn=%h perm=%0d ctx=%0d expected hit=%0b walk=%0b pfn=%h perm=%0d ctx=%0d",
                     tag, lk_vpn, lk_write, lk_hit, lk_need_walk, lk_pfn, lk_perm, cur_ctx,
                     eh, en, ep, epm, m_cur);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic look(input int vpn, input bit wr, input string tag);
        lk_vpn = VPN_W'(vpn); lk_write = wr; fl_valid = 0; mt_op = 3'd0;
        step(tag);
    endtask

    task automatic fill(input int vpn, input int pfn, input int perm, input bit d,
                        input bit a, input string tag);
        lk_vpn = VPN_W'(vpn); lk_write = 0;
        fl_valid = 1; fl_vpn = VPN_W'(vpn); fl_pfn = PFN_W'(pfn); fl_perm = PERM_W'(perm);
        fl_dirty = d; fl_accessed = a; mt_op = 3'd0;
        step(tag);
        fl_valid = 0;
    endtask

    task automatic maint(input int op, input int vpn, input int ctx, input bit te,
                         input bit with_fill, input string tag);
        fl_valid = with_fill; mt_op = 3'(op); mt_vpn = VPN_W'(vpn);
        mt_ctx = CTX_W'(ctx); tag_en = te;
        step(tag);
        fl_valid = 0; mt_op = 3'd0;
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_v[i] = 0; m_d[i] = 0; m_a[i] = 0;
            m_vpn[i] = 0; m_pfn[i] = 0; m_perm[i] = 0; m_ctx[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        look('h100, 0, "R1");
        look('h0, 0, "R1");
        // R4: accessed/dirty handling
        fill('h100, 'hAAA, 5, 0, 0, "R12");
        look('h100, 0, "R4");
        fill('h100, 'hAAA, 5, 0, 1, "R5");
        look('h100, 0, "R2");
        look('h100, 1, "R4");
        fill('h100, 'hAAA, 5, 1, 1, "R5");
        look('h100, 1, "R4");
        look('h101, 0, "R2");
        // R7 and R3: tagged root switch keeps entries
        maint(1, 0, 3, 1, 0, "R7");
        look('h100, 0, "R3");
        fill('h100, 'hBBB, 6, 1, 1, "R3");
        look('h100, 0, "R3");
        maint(1, 0, 0, 1, 0, "R7");
        look('h100, 0, "R7");
        // R5: overflow into round-robin replacement
        for (int i = 0; i < 20; i++) fill('h200 + i, 'h300 + i, i % 8, 1, 1, "R5");
        for (int i = 0; i < 20; i++) look('h200 + i, 0, "R5");
        look('h100, 0, "R5");
        // R12: fill together with a root load uses the old tag
        fl_vpn = VPN_W'('h400); fl_pfn = PFN_W'('h444); fl_perm = 3'd7;
        fl_dirty = 1; fl_accessed = 1;
        maint(1, 0, 5, 1, 1, "R12");
        look('h400, 0, "R12");
        maint(1, 0, 0, 1, 0, "R7");
        look('h400, 0, "R12");
        // R8: page invalidate across tags
        maint(1, 0, 3, 1, 0, "R7");
        look('h100, 0, "R8");
        maint(2, 'h100, 0, 1, 0, "R8");
        look('h100, 0, "R8");
        maint(1, 0, 0, 1, 0, "R8");
        look('h100, 0, "R8");
        // R10: flush one tag
        maint(1, 0, 3, 1, 0, "R10");
        fill('h500, 'h555, 1, 1, 1, "R10");
        fill('h501, 'h556, 2, 1, 1, "R10");
        maint(1, 0, 0, 1, 0, "R10");
        look('h210, 0, "R10");
        maint(4, 0, 3, 1, 0, "R10");
        look('h210, 0, "R10");
        maint(1, 0, 3, 1, 0, "R10");
        look('h500, 0, "R10");
        look('h501, 0, "R10");
        maint(1, 0, 0, 1, 0, "R10");
        // R11: invalidate beats a same-cycle fill of that page
        fl_vpn = VPN_W'('h600); fl_pfn = PFN_W'('h666); fl_perm = 3'd3;
        fl_dirty = 1; fl_accessed = 1;
        maint(2, 'h600, 0, 1, 1, "R11");
        look('h600, 0, "R11");
        fl_vpn = VPN_W'('h601); fl_pfn = PFN_W'('h667);
        maint(2, 'h602, 0, 1, 1, "R11");
        look('h601, 0, "R11");
        // R9: flush all
        maint(3, 0, 0, 1, 0, "R9");
        look('h601, 0, "R9");
        look('h213, 0, "R9");
        // R6: untagged root load flushes
        fill('h700, 'h777, 4, 1, 1, "R6");
        look('h700, 0, "R6");
        maint(1, 0, 9, 0, 0, "R6");
        maint(1, 0, 0, 1, 0, "R6");
        look('h700, 0, "R6");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule